// File: doc/BRIEF.md
# Cell-Granular Transmit Buffer with Selectable Depth

This block holds whole transmit cells between a cell receiver and a downstream cell processor. Its storage is a physical array of sixteen cell slots, but only the number of slots chosen by a configuration input is in use. The receiver writes each cell one word per cycle into a tentative slot. That slot becomes visible to the reader only when the final word arrives with its end marker. A short cell, an overlong cell, or a cell aborted by the receiver is rolled back, and the cells already committed are not touched.

The write side sees three flags: empty, full, and a cell-available flag. The cell-available flag is true only while a further complete cell would fit beyond any cell still being written. It drives the handshake that throttles the sending layer. The reader asks for a cell with a start request. The block then streams exactly one cell of words in order, marks the final word, and frees the slot.

Top module: `cfifo_top`

## Requirements
- R1: After reset `empty`=1, `full`=0, `cell_avail`=1 and `rd_valid`=0. No cell is stored, and the depth is taken from `cfg_depth`.
- R2: `cfg_depth` selects the usable depth as 4·(code+1) cells: 2'b00→4, 2'b01→8, 2'b10→12, 2'b11→16. `full` is 1 exactly when the number of committed cells equals that depth.
- R3: A cell is committed when its word at offset CELL_WORDS-1 is written with `wr_last`=1 and `wr_abort`=0. The count rises at that clock edge, so `empty` falls right after it.
- R4: `wr_abort`=1 (with or without `wr_valid`) discards the partially written cell, including any word presented in that cycle. Committed cells keep their data and order, and the next cell starts at offset 0.
- R5: A word carrying `wr_last`=1 at an offset below CELL_WORDS-1 (a runt) discards the whole cell. Nothing reaches the read side.
- R6: A word at offset CELL_WORDS-1 without `wr_last` (an overlong cell) discards the whole cell.
- R7: `cell_avail` is 1 exactly when (committed cells + 1 if a cell is partly written) is less than the usable depth. It is therefore 0 whenever `full` is 1.
- R8: A word offered while committed cells equal the usable depth is ignored. Stored data and flags are unchanged.
- R9: `rd_start` accepted at a clock edge causes CELL_WORDS words on `rd_data` with `rd_valid`=1, starting two edges later, in the order they were written and oldest cell first. `rd_last`=1 marks only the final word, and the count drops at the edge that outputs that word.
- R10: `rd_start` is ignored while `empty`=1 or while a cell is being streamed.
- R11: A new `cfg_depth` is taken only at an edge where no cell is committed and no cell is partly written. Otherwise the previous depth stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_depth | input | 2 | Usable depth code |
| wr_valid | input | 1 | Write word strobe |
| wr_data | input | DATA_W | Write word |
| wr_last | input | 1 | Marks the final word of a cell |
| wr_abort | input | 1 | Discard the partially written cell |
| rd_start | input | 1 | Request to stream one cell |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DATA_W | Read word |
| rd_last | output | 1 | Final word of the streamed cell |
| empty | output | 1 | No committed cell |
| full | output | 1 | Committed cells equal usable depth |
| cell_avail | output | 1 | Room for another complete cell |

## Verification
The bench fills the buffer to each selectable depth and then offers one extra cell. A design that compared against the physical size would accept that cell, and it would show up in the read data. Runts, overlong cells and aborts are mixed between good cells and checked word by word on the read side. A design that did not rewind its tentative pointer would shift or corrupt later cells. The bench also checks the flags in the middle of a cell written into the last free slot, where a design that looked only at committed cells would keep `cell_avail` high. Depth changes are issued while cells are stored, which catches a design that resizes early and reports `full` at the wrong count. Start requests are held through a whole read and issued while the buffer is empty, which catches a design that streams an extra or phantom cell.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

  function automatic int unsigned depth_cells(input logic [1:0] code, input int unsigned slots);
    return ((int'(code) + 1) * slots) / 4;
  endfunction

  function automatic int unsigned cell_addr(input int unsigned slot, input int unsigned word,
                                            input int unsigned cell_words);
    return slot * cell_words + word;
  endfunction

  function automatic int unsigned next_slot(input int unsigned slot, input int unsigned slots);
    return (slot == slots - 1) ? 0 : slot + 1;
  endfunction

endpackage

// File: rtl/cfifo_mem.sv
module cfifo_mem #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 432,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/cfifo_wr_ctrl.sv
module cfifo_wr_ctrl
  import cfifo_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int CELL_WORDS = 27,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int WORD_W = $clog2(CELL_WORDS),
  localparam int ADDR_W = $clog2(SLOTS * CELL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_last,
  input  logic              wr_abort,
  input  logic              room,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              commit,
  output logic              discard,
  output logic              open
);
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] off_q;
  logic              accept, at_end, shape_bad;

  assign accept    = wr_valid && room && !wr_abort;
  assign at_end    = (off_q == WORD_W'(CELL_WORDS - 1));
  assign commit    = accept && wr_last && at_end;
  assign shape_bad = accept && (wr_last != at_end);
  assign discard   = shape_bad || wr_abort;
  assign open      = (off_q != '0);
  assign wr_en     = accept;
  assign wr_addr   = ADDR_W'(cell_addr(int'(slot_q), int'(off_q), CELL_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      off_q  <= '0;
    end else begin
      if (discard || commit) off_q <= '0;
      else if (accept)       off_q <= off_q + 1'b1;
      if (commit) slot_q <= SLOT_W'(next_slot(int'(slot_q), SLOTS));
    end
  end
endmodule

// File: rtl/cfifo_rd_ctrl.sv
module cfifo_rd_ctrl
  import cfifo_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int CELL_WORDS = 27,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int WORD_W = $clog2(CELL_WORDS),
  localparam int ADDR_W = $clog2(SLOTS * CELL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              empty,
  output logic              rd_go,
  output logic              busy,
  output logic              rd_done,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic              rd_last
);
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] word_q;

  assign rd_go   = rd_start && !busy && !empty;
  assign rd_done = busy && (word_q == WORD_W'(CELL_WORDS - 1));
  assign rd_addr = ADDR_W'(cell_addr(int'(slot_q), int'(word_q), CELL_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      word_q   <= '0;
      busy     <= 1'b0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= busy;
      rd_last  <= rd_done;
      if (rd_go) begin
        busy   <= 1'b1;
        word_q <= '0;
      end else if (rd_done) begin
        busy   <= 1'b0;
        word_q <= '0;
        slot_q <= SLOT_W'(next_slot(int'(slot_q), SLOTS));
      end else if (busy) begin
        word_q <= word_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfifo_top.sv
module cfifo_top
  import cfifo_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CELL_WORDS = 27,
  parameter int SLOTS      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_depth,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              wr_abort,
  input  logic              rd_start,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              empty,
  output logic              full,
  output logic              cell_avail
);
  localparam int WORDS  = SLOTS * CELL_WORDS;
  localparam int ADDR_W = $clog2(WORDS);
  localparam int CNT_W  = $clog2(SLOTS + 2);

  logic [CNT_W-1:0]  count_q, depth_q;
  logic              commit_ev, discard_ev, wr_open, wr_en, room;
  logic              rd_go_ev, rd_busy, rd_done_ev;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              resize_ok;

  assign room       = (count_q < depth_q);
  assign empty      = (count_q == '0);
  assign full       = (count_q == depth_q);
  assign cell_avail = ((count_q + CNT_W'(wr_open)) < depth_q);
  assign resize_ok  = empty && !wr_open;

  cfifo_wr_ctrl #(.SLOTS(SLOTS), .CELL_WORDS(CELL_WORDS)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last),
    .wr_abort(wr_abort), .room(room), .wr_en(wr_en), .wr_addr(wr_addr),
    .commit(commit_ev), .discard(discard_ev), .open(wr_open)
  );

  cfifo_rd_ctrl #(.SLOTS(SLOTS), .CELL_WORDS(CELL_WORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .empty(empty),
    .rd_go(rd_go_ev), .busy(rd_busy), .rd_done(rd_done_ev), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_last(rd_last)
  );

  cfifo_mem #(.DATA_W(DATA_W), .WORDS(WORDS)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_busy), .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      depth_q <= CNT_W'(depth_cells(cfg_depth, SLOTS));
    end else begin
      case ({commit_ev, rd_done_ev})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (resize_ok) depth_q <= CNT_W'(depth_cells(cfg_depth, SLOTS));
    end
  end
endmodule

// File: rtl/cfifo_chk.sv
module cfifo_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] depth,
  input logic             commit,
  input logic             rd_done,
  input logic             rd_go,
  input logic             open,
  input logic             rd_valid,
  input logic             rd_last,
  input logic             full,
  input logic             cell_avail
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth); // R8
  AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !rd_done |=> count == $past(count) + 1'b1); // R3
  AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !commit |=> count == $past(count) - 1'b1); // R9
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_valid ##1 rd_valid); // R9
  AST_LAST_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid); // R9
  AST_AVAIL_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    cell_avail |-> !full); // R7
  AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) || open |=> $stable(depth)); // R11
endmodule

bind cfifo_top cfifo_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count_q), .depth(depth_q),
  .commit(commit_ev), .rd_done(rd_done_ev), .rd_go(rd_go_ev), .open(wr_open),
  .rd_valid(rd_valid), .rd_last(rd_last), .full(full), .cell_avail(cell_avail)
);

// File: tb/tb_cfifo_top.sv
`timescale 1ns/1ps
module tb_cfifo_top;
  localparam int CW = 27;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_depth = 2'b00;
  logic wr_valid = 0, wr_last = 0, wr_abort = 0, rd_start = 0;
  logic [DW-1:0] wr_data = '0;
  logic rd_valid, rd_last, empty, full, cell_avail;
  logic [DW-1:0] rd_data;

  always #4 clk = ~clk;

  cfifo_top #(.DATA_W(DW), .CELL_WORDS(CW), .SLOTS(16)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_last(wr_last), .wr_abort(wr_abort), .rd_start(rd_start),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .empty(empty), .full(full), .cell_avail(cell_avail)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] pbuf[$];
  int mcount = 0, moff = 0, mdepth = 4;

  function automatic int dmap(input logic [1:0] c);
    return 4 * (int'(c) + 1);
  endfunction

  function automatic bit exp_avail(input int cnt, input int off, input int dep);
    return (cnt + (off != 0 ? 1 : 0)) < dep;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    chk(empty == (mcount == 0), {tag, " empty"}, int'(empty), int'(mcount == 0));
    chk(full == (mcount == mdepth), {tag, " full"}, int'(full), int'(mcount == mdepth));
    chk(cell_avail == exp_avail(mcount, moff, mdepth), {tag, " cell_avail"},
        int'(cell_avail), int'(exp_avail(mcount, moff, mdepth)));
  endtask

  task automatic model_resize();
    if (mcount == 0 && moff == 0) mdepth = dmap(cfg_depth);
  endtask

  task automatic wr_word(input logic [DW-1:0] d, input bit l, input bit a, input bit v);
    int pre_cnt = mcount, pre_dep = mdepth;
    model_resize();
    wr_valid = v; wr_data = d; wr_last = l; wr_abort = a;
    @(negedge clk);
    wr_valid = 0; wr_last = 0; wr_abort = 0;
    if (a) begin
      moff = 0; pbuf.delete();
    end else if (v && pre_cnt < pre_dep) begin
      pbuf.push_back(d);
      if (moff == CW - 1) begin
        if (l) begin
          foreach (pbuf[i]) mq.push_back(pbuf[i]);
          mcount++;
        end
        moff = 0; pbuf.delete();
      end else if (l) begin
        moff = 0; pbuf.delete();
      end else moff++;
    end
  endtask

  task automatic idle_cyc();
    model_resize();
    @(negedge clk);
  endtask

  // kind: 0 good, 1 runt, 2 overlong, 3 abort
  task automatic write_cell(input int kind);
    int n;
    case (kind)
      0: for (int i = 0; i < CW; i++) wr_word(DW'($urandom), i == CW - 1, 0, 1);
      1: begin
        n = 1 + ($urandom % (CW - 1));
        for (int i = 0; i < n; i++) wr_word(DW'($urandom), i == n - 1, 0, 1);
      end
      2: for (int i = 0; i < CW; i++) wr_word(DW'($urandom), 0, 0, 1);
      default: begin
        n = 1 + ($urandom % (CW - 1));
        for (int i = 0; i < n; i++) wr_word(DW'($urandom), 0, 0, 1);
        wr_word(DW'($urandom), 0, 1, $urandom % 2);
      end
    endcase
  endtask

  task automatic read_cell(input string tag);
    if (mcount == 0) begin
      rd_start = 1;
      for (int i = 0; i < 4; i++) begin
        idle_cyc();
        chk(rd_valid == 0, {tag, " R10 start while empty"}, int'(rd_valid), 0);
      end
      rd_start = 0;
      return;
    end
    rd_start = 1;
    @(negedge clk);
    chk(rd_valid == 0, {tag, " R9 latency"}, int'(rd_valid), 0);
    for (int i = 0; i < CW; i++) begin
      @(negedge clk);
      chk(rd_valid == 1, {tag, " R9 valid"}, int'(rd_valid), 1);
      chk(rd_data == mq[i], {tag, " R9 data order"}, int'(rd_data), int'(mq[i]));
      chk(rd_last == (i == CW - 1), {tag, " R9 last"}, int'(rd_last), int'(i == CW - 1));
    end
    rd_start = 0;
    for (int i = 0; i < CW; i++) void'(mq.pop_front());
    mcount--;
    idle_cyc();
    chk(rd_valid == 0, {tag, " R10 start while busy"}, int'(rd_valid), 0);
    check_flags({tag, " R9 after read"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int k;
    void'($urandom(32'h5EED_0007));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mdepth = dmap(cfg_depth);
    chk(rd_valid == 0, "R1 rd_valid", int'(rd_valid), 0);
    check_flags("R1 reset");

    // R2 / R8: every depth filled, then one extra cell offered
    for (int c = 0; c < 4; c++) begin
      cfg_depth = 2'(c);
      idle_cyc();
      for (int n = 0; n < dmap(2'(c)); n++) write_cell(0);
      check_flags("R2 filled");
      write_cell(0);
      check_flags("R8 extra cell ignored");
      while (mcount > 0) read_cell("R8 drain");
      read_cell("R10 empty");
    end

    // R7: partial cell into the last free slot
    cfg_depth = 2'b00; idle_cyc();
    for (int n = 0; n < 3; n++) write_cell(0);
    for (int i = 0; i < CW - 1; i++) wr_word(DW'($urandom), 0, 0, 1);
    check_flags("R7 partial in last slot");
    wr_word(16'hA5A5, 1, 0, 1);
    check_flags("R7 committed");

    // R11: depth change while cells stored
    cfg_depth = 2'b11;
    read_cell("R11 read");
    idle_cyc();
    write_cell(0);
    check_flags("R11 old depth kept");
    while (mcount > 0) read_cell("R11 drain");
    idle_cyc();
    write_cell(0);
    check_flags("R11 new depth");

    // R4 R5 R6 directed between good cells
    write_cell(3); check_flags("R4 abort");
    write_cell(1); check_flags("R5 runt");
    write_cell(2); check_flags("R6 overlong");
    write_cell(0); check_flags("R3 commit");
    while (mcount > 0) read_cell("R4 R5 R6 drain");

    // random mix
    for (int n = 0; n < 250; n++) begin
      k = $urandom % 10;
      if (k < 4) begin write_cell(0); check_flags("R3 random good"); end
      else if (k == 4) begin write_cell(1); check_flags("R5 random runt"); end
      else if (k == 5) begin write_cell(2); check_flags("R6 random overlong"); end
      else if (k == 6) begin write_cell(3); check_flags("R4 random abort"); end
      else if (k < 9) read_cell("R9 random read");
      else begin cfg_depth = 2'($urandom); idle_cyc(); check_flags("R11 random depth"); end
    end
    while (mcount > 0) read_cell("R9 final drain");
    check_flags("R9 final");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule